// File: doc/BRIEF.md
# Watchdog Timer with Level or Pulse Reset Output

This block is a watchdog device reached through the byte-wide register port of a configuration space. A prescaler turns the system clock into a millisecond tick, and from that tick it derives second and minute ticks. An 8-bit count runs down in whichever unit software selects. When the count runs out, the block drives an active-low reset output and latches a timeout status flag. The output either stays low as a held level or gives one low pulse, with four encoded widths to choose from.

Software keeps the system alive by rewriting the time register. Each write reloads the count and restarts the prescaler. The watchdog runs only while both the device enable and the timer enable are set. A separate output enable decides whether an expiry reaches the pin at all. The status flag survives the reset it causes and is cleared by writing a one to it.

Two state machines do the work. The countdown machine has the states CD_IDLE, CD_COUNT and CD_EXPIRED. Its transitions are:
- idle to count, when the block starts running;
- count to expired, on the unit tick that exhausts the count;
- expired or count back to count, on a reload;
- any state to idle, when running stops.

The shaper machine has the states SH_OFF, SH_LEVEL, SH_PULSE and SH_DONE. Its transitions are:
- off to level or off to pulse, on expiry, with the choice made by the mode bit;
- pulse to done, when the width has elapsed;
- level, pulse or done back to off, when the expired state ends.

Top module: `wdt_reset_timer`

## Requirements
- R1: After reset `wd_rst_n` is 1, and all four registers (device enable 0x30, output enable 0xF0, configuration 0xF5, time 0xF6) read 0.
- R2: The register fields are laid out as follows.
  - Configuration 0xF5: bits 1:0 select the pulse width, bit 3 selects minutes (1) or seconds (0), bit 4 selects pulse mode (1) or level mode (0), bit 5 enables the timer, and bit 6 is the status flag.
  - 0xF5 bits 2 and 7 read 0.
  - 0x30 bit 0 is the device enable and 0xF0 bit 7 is the output enable. All other bits of these two registers read 0.
  - 0xF6 reads the live count.
- R3: In seconds mode with count N≥1, `wd_rst_n` first reads 0 on the cycle N·U+1 after the write edge that starts the timer, where U = TICK_DIV·MS_PER_SEC.
- R4: In minutes mode the unit is U·SEC_PER_MIN. The live count drops by one at every unit tick.
- R5: A count of 0 expires on the first unit tick, the same as a count of 1.
- R6: Writing 0xF6 reloads the count and restarts the prescaler, so the expiry is timed afresh from that write. A write during expiry returns `wd_rst_n` to 1 on the next cycle.
- R7: In level mode `wd_rst_n` stays 0 until a reload or a disable. Clearing the timer enable stops the count and sets `wd_rst_n` to 1 on the next cycle.
- R8: In pulse mode the width codes 0, 1, 2 and 3 give a low pulse of PW_MSk·TICK_DIV cycles. The output then stays high while the block remains expired.
- R9: The timer runs only when both 0x30 bit 0 and 0xF5 bit 5 are set. With 0xF0 bit 7 clear, an expiry leaves `wd_rst_n` at 1 but still sets the status flag.
- R10: The status flag is set on expiry and is not cleared by the pulse that follows. Writing 1 to 0xF5 bit 6 clears it; writing 0 there leaves it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low block reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| wd_rst_n | output | 1 | Active-low watchdog reset output |

## Verification
The bench sweeps counts in both units, counts the cycles to the falling edge of the output, and checks them against N·U+1. An off-by-one in the countdown, or a count of zero that never expires, shows up as a wrong cycle count. All four pulse codes are timed. A swapped or truncated width table gives a pulse of the wrong length, and a shaper that re-fires while expired gives a second low edge. Reloads are applied both mid-count and during expiry, and the status flag is written with both 0 and 1. A prescaler that is not restarted would expire early. A status flag that clears on the wrong value, or is lost after the pulse, reads back wrong.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam logic [7:0] ADDR_DEV  = 8'h30;
    localparam logic [7:0] ADDR_OUT  = 8'hF0;
    localparam logic [7:0] ADDR_CFG  = 8'hF5;
    localparam logic [7:0] ADDR_TIME = 8'hF6;

    localparam int BIT_STAT  = 6;
    localparam int BIT_TEN   = 5;
    localparam int BIT_PULSE = 4;
    localparam int BIT_UNIT  = 3;
    localparam int BIT_OEN   = 7;

    typedef enum logic [1:0] {CD_IDLE, CD_COUNT, CD_EXPIRED} cd_state_e;
    typedef enum logic [1:0] {SH_OFF, SH_LEVEL, SH_PULSE, SH_DONE} sh_state_e;
endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
    parameter int TICK_DIV    = 125000,
    parameter int MS_PER_SEC  = 1000,
    parameter int SEC_PER_MIN = 60
) (
    input  logic clk,
    input  logic arst_n,
    input  logic clr,
    input  logic unit_min,
    output logic unit_tick
);
    localparam int MSW = $clog2(TICK_DIV);
    localparam int SW  = $clog2(MS_PER_SEC);
    localparam int NW  = $clog2(SEC_PER_MIN);

    logic [MSW-1:0] ms_q;
    logic [SW-1:0]  sec_q;
    logic [NW-1:0]  min_q;
    logic ms_tick, sec_tick, min_tick;

    assign ms_tick  = !clr && (ms_q == MSW'(TICK_DIV - 1));
    assign sec_tick = ms_tick && (sec_q == SW'(MS_PER_SEC - 1));
    assign min_tick = sec_tick && (min_q == NW'(SEC_PER_MIN - 1));
    assign unit_tick = unit_min ? min_tick : sec_tick;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            ms_q  <= '0;
            sec_q <= '0;
            min_q <= '0;
        end else if (clr) begin
            ms_q  <= '0;
            sec_q <= '0;
            min_q <= '0;
        end else begin
            ms_q <= ms_tick ? '0 : ms_q + 1'b1;
            if (ms_tick)  sec_q <= sec_tick ? '0 : sec_q + 1'b1;
            if (sec_tick) min_q <= min_tick ? '0 : min_q + 1'b1;
        end
    end

    // R6
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!arst_n)
        clr |=> !unit_tick);
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       arst_n,
    input  logic       running,
    input  logic       reload,
    input  logic [7:0] reload_val,
    input  logic       unit_tick,
    output logic [7:0] cnt_o,
    output logic       expired_o,
    output logic       expire_evt
);
    cd_state_e  state_q, state_d;
    logic [7:0] cnt_q, cnt_d;

    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        expire_evt = 1'b0;
        if (reload) cnt_d = reload_val;
        if (!running) begin
            state_d = CD_IDLE;
        end else if (reload) begin
            state_d = CD_COUNT;
        end else begin
            unique case (state_q)
                CD_IDLE:    state_d = CD_COUNT;
                CD_COUNT: begin
                    if (unit_tick) begin
                        if (cnt_q <= 8'd1) begin
                            state_d    = CD_EXPIRED;
                            cnt_d      = 8'd0;
                            expire_evt = 1'b1;
                        end else begin
                            cnt_d = cnt_q - 8'd1;
                        end
                    end
                end
                CD_EXPIRED: state_d = CD_EXPIRED;
                default:    state_d = CD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= CD_IDLE;
            cnt_q   <= 8'd0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign cnt_o     = cnt_q;
    assign expired_o = (state_q == CD_EXPIRED);

    // R4
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == CD_COUNT && running && !reload && unit_tick && cnt_q > 8'd1)
        |=> cnt_q == $past(cnt_q) - 8'd1);
    // R7
    halt_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !running |=> state_q == CD_IDLE);
endmodule

// File: rtl/wdt_shaper.sv
module wdt_shaper
    import wdt_pkg::*;
#(
    parameter int unsigned W0 = 125000,
    parameter int unsigned W1 = 3125000,
    parameter int unsigned W2 = 15625000,
    parameter int unsigned W3 = 625000000
) (
    input  logic       clk,
    input  logic       arst_n,
    input  logic       expired,
    input  logic       mode_pulse,
    input  logic [1:0] pw_sel,
    output logic       active
);
    sh_state_e   state_q, state_d;
    logic [31:0] pc_q, pc_d, width;

    always_comb begin
        unique case (pw_sel)
            2'd0: width = W0;
            2'd1: width = W1;
            2'd2: width = W2;
            2'd3: width = W3;
            default: width = W0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        unique case (state_q)
            SH_OFF: if (expired) begin
                state_d = mode_pulse ? SH_PULSE : SH_LEVEL;
                pc_d    = width - 32'd1;
            end
            SH_LEVEL: if (!expired) state_d = SH_OFF;
            SH_PULSE: begin
                if (!expired)          state_d = SH_OFF;
                else if (pc_q == 32'd0) state_d = SH_DONE;
                else                   pc_d = pc_q - 32'd1;
            end
            SH_DONE: if (!expired) state_d = SH_OFF;
            default: state_d = SH_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= SH_OFF;
            pc_q    <= 32'd0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    always_comb begin
        active = (state_q == SH_LEVEL) || (state_q == SH_PULSE);
    end

    // R8
    raise_when_expired_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(active) |-> $past(expired));
endmodule

// File: rtl/wdt_reset_timer.sv
module wdt_reset_timer
    import wdt_pkg::*;
#(
    parameter int TICK_DIV    = 125000,
    parameter int MS_PER_SEC  = 1000,
    parameter int SEC_PER_MIN = 60,
    parameter int PW_MS0      = 1,
    parameter int PW_MS1      = 25,
    parameter int PW_MS2      = 125,
    parameter int PW_MS3      = 5000
) (
    input  logic       clk,
    input  logic       arst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    output logic       wd_rst_n
);
    localparam int unsigned W0 = PW_MS0 * TICK_DIV;
    localparam int unsigned W1 = PW_MS1 * TICK_DIV;
    localparam int unsigned W2 = PW_MS2 * TICK_DIV;
    localparam int unsigned W3 = PW_MS3 * TICK_DIV;

    logic       dev_en_q, out_en_q, ten_q, pmode_q, unit_q, stat_q;
    logic [1:0] pw_q;
    logic [7:0] cnt;
    logic       running, reload, unit_tick, expired, expire_evt, active;

    assign running = dev_en_q && ten_q;
    assign reload  = cfg_we && (cfg_addr == ADDR_TIME);

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            dev_en_q <= 1'b0;
            out_en_q <= 1'b0;
            ten_q    <= 1'b0;
            pmode_q  <= 1'b0;
            unit_q   <= 1'b0;
            pw_q     <= 2'd0;
            stat_q   <= 1'b0;
        end else begin
            if (cfg_we && cfg_addr == ADDR_DEV) dev_en_q <= cfg_wdata[0];
            if (cfg_we && cfg_addr == ADDR_OUT) out_en_q <= cfg_wdata[BIT_OEN];
            if (cfg_we && cfg_addr == ADDR_CFG) begin
                ten_q   <= cfg_wdata[BIT_TEN];
                pmode_q <= cfg_wdata[BIT_PULSE];
                unit_q  <= cfg_wdata[BIT_UNIT];
                pw_q    <= cfg_wdata[1:0];
            end
            if (expire_evt)
                stat_q <= 1'b1;
            else if (cfg_we && cfg_addr == ADDR_CFG && cfg_wdata[BIT_STAT])
                stat_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (cfg_addr)
            ADDR_DEV:  cfg_rdata = {7'd0, dev_en_q};
            ADDR_OUT:  cfg_rdata = {out_en_q, 7'd0};
            ADDR_CFG:  cfg_rdata = {1'b0, stat_q, ten_q, pmode_q, unit_q, 1'b0, pw_q};
            ADDR_TIME: cfg_rdata = cnt;
            default:   cfg_rdata = 8'd0;
        endcase
    end

    wdt_timebase #(
        .TICK_DIV(TICK_DIV), .MS_PER_SEC(MS_PER_SEC), .SEC_PER_MIN(SEC_PER_MIN)
    ) u_tb (
        .clk(clk), .arst_n(arst_n), .clr(!running || reload),
        .unit_min(unit_q), .unit_tick(unit_tick)
    );

    wdt_countdown u_cd (
        .clk(clk), .arst_n(arst_n), .running(running), .reload(reload),
        .reload_val(cfg_wdata), .unit_tick(unit_tick), .cnt_o(cnt),
        .expired_o(expired), .expire_evt(expire_evt)
    );

    wdt_shaper #(.W0(W0), .W1(W1), .W2(W2), .W3(W3)) u_sh (
        .clk(clk), .arst_n(arst_n), .expired(expired), .mode_pulse(pmode_q),
        .pw_sel(pw_q), .active(active)
    );

    assign wd_rst_n = !(active && expired && out_en_q && running);

    // R10
    stat_set_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(expired) |-> stat_q);
    // R9
    idle_no_expire_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (!dev_en_q && !$past(dev_en_q)) |-> !expired);
endmodule

// File: tb/wdt_reset_timer_tb.sv
`timescale 1ns/1ps
module wdt_reset_timer_tb;
    localparam int D = 4, M = 4, S = 3;
    localparam int U  = D * M;
    localparam int UM = U * S;
    localparam int PW [4] = '{1, 2, 3, 5};

    logic clk = 1'b0, arst_n = 1'b0, cfg_we = 1'b0;
    logic [7:0] cfg_addr = 8'd0, cfg_wdata = 8'd0, cfg_rdata;
    logic wd_rst_n;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    wdt_reset_timer #(.TICK_DIV(D), .MS_PER_SEC(M), .SEC_PER_MIN(S),
        .PW_MS0(PW[0]), .PW_MS1(PW[1]), .PW_MS2(PW[2]), .PW_MS3(PW[3])) u_dut (
        .clk(clk), .arst_n(arst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wd_rst_n(wd_rst_n));

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        cfg_addr = a;
        #1;
        d = int'(cfg_rdata);
    endtask

    task automatic do_reset();
        @(negedge clk);
        arst_n = 1'b0;
        repeat (2) @(negedge clk);
        arst_n = 1'b1;
    endtask

    task automatic wait_low(input int lim, output int k);
        k = 0;
        while (wd_rst_n && k < lim) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic start(input logic [7:0] n, input logic [7:0] cfg, input logic oen);
        do_reset();
        wr(8'h30, 8'h01);
        wr(8'hF0, oen ? 8'h80 : 8'h00);
        wr(8'hF6, n);
        wr(8'hF5, cfg);
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int v, k;
        do_reset();
        // R1 reset state
        chk(int'(wd_rst_n), 1, "R1 output");
        rd(8'h30, v); chk(v, 0, "R1 dev");
        rd(8'hF0, v); chk(v, 0, "R1 out");
        rd(8'hF5, v); chk(v, 0, "R1 cfg");
        rd(8'hF6, v); chk(v, 0, "R1 time");

        // R2 field layout and readback (device disabled so nothing runs)
        wr(8'hF5, 8'hFF); rd(8'hF5, v); chk(v, 8'h3B, "R2 cfg");
        wr(8'hF6, 8'hA5); rd(8'hF6, v); chk(v, 8'hA5, "R2 time");
        wr(8'hF0, 8'hFF); rd(8'hF0, v); chk(v, 8'h80, "R2 out");
        wr(8'h30, 8'hFF); rd(8'h30, v); chk(v, 8'h01, "R2 dev");

        // R3 seconds sweep, R5 zero count
        for (int n = 0; n <= 5; n++) begin
            start(8'(n), 8'h20, 1'b1);
            wait_low(400, k);
            chk(k, ((n == 0) ? 1 : n) * U + 1, (n == 0) ? "R5 sec zero" : "R3 sec");
        end
        // R4 minutes sweep
        for (int n = 0; n <= 2; n++) begin
            start(8'(n), 8'h28, 1'b1);
            wait_low(400, k);
            chk(k, ((n == 0) ? 1 : n) * UM + 1, "R4 min");
        end
        // R4 live decrement
        start(8'd5, 8'h20, 1'b1);
        repeat (2 * U - 1) @(negedge clk);
        rd(8'hF6, v); chk(v, 4, "R4 before tick");
        @(negedge clk);
        rd(8'hF6, v); chk(v, 3, "R4 after tick");

        // R8 pulse widths, R10 status kept after pulse
        for (int s = 0; s < 4; s++) begin
            int w;
            start(8'd1, 8'(8'h30 | s), 1'b1);
            wait_low(400, k);
            chk(k, U + 1, "R8 pulse start");
            w = 0;
            while (!wd_rst_n && w < 100) begin
                @(negedge clk);
                w++;
            end
            chk(w, PW[s] * D, "R8 pulse width");
            repeat (30) @(negedge clk);
            chk(int'(wd_rst_n), 1, "R8 no refire");
            rd(8'hF5, v); chk((v >> 6) & 1, 1, "R10 status after pulse");
        end

        // R7 level held then disable
        start(8'd1, 8'h20, 1'b1);
        wait_low(400, k);
        repeat (50) @(negedge clk);
        chk(int'(wd_rst_n), 0, "R7 level held");
        wr(8'hF5, 8'h00);
        chk(int'(wd_rst_n), 1, "R7 disable releases");
        rd(8'hF5, v); chk((v >> 6) & 1, 1, "R10 status survives disable");

        // R6 keepalive mid-count
        start(8'd3, 8'h20, 1'b1);
        repeat (40) @(negedge clk);
        wr(8'hF6, 8'd3);
        wait_low(400, k);
        chk(k, 3 * U + 1, "R6 keepalive");
        // R6 reload during expiry
        wr(8'hF6, 8'd2);
        chk(int'(wd_rst_n), 1, "R6 reload releases");
        wait_low(400, k);
        chk(k, 2 * U + 1, "R6 re-expiry");

        // R9 device enable off
        do_reset();
        wr(8'hF0, 8'h80); wr(8'hF6, 8'd1); wr(8'hF5, 8'h20);
        wait_low(200, k);
        chk(k, 200, "R9 dev off no expiry");
        rd(8'hF5, v); chk((v >> 6) & 1, 0, "R9 dev off no status");
        // R9 output enable off
        start(8'd1, 8'h20, 1'b0);
        wait_low(60, k);
        chk(k, 60, "R9 out off pin high");
        rd(8'hF5, v); chk((v >> 6) & 1, 1, "R9 out off status set");

        // R10 clear semantics
        wr(8'hF5, 8'h20);
        rd(8'hF5, v); chk((v >> 6) & 1, 1, "R10 write0 keeps");
        wr(8'hF5, 8'h40);
        rd(8'hF5, v); chk((v >> 6) & 1, 0, "R10 write1 clears");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule